// File: doc/BRIEF.md
# Push-Pull Gate Control Logic

This block converts logic-level commands into on/off requests for the high-side and low-side switches of a push-pull output stage. A mode input selects between two ways of controlling it. In the two-input mode, each switch follows its own command, and an interlock stops both from turning on together. In the one-input mode, a single command drives the two switches in opposite phase, and a programmable dead time separates one switch turning off from the other turning on.

Every on-pulse is stretched to a minimum width. The switches start only after an enable-on delay. Either enable going low or the power-on-reset level going low drops both switches at the next clock edge. A fault block can force each side off through its own kill input, and a kill takes effect before the minimum width has run out. All times are parameters in nanoseconds. The block converts them to clock cycles by rounding up. The dead time is a count of cycles supplied at run time.

Top module: `pp_gate_ctrl`

## Requirements
- R1: With `dual_mode`=1, `ctl_hi` alone turns `hi_on` on and `ctl_lo` alone turns `lo_on` on. A side whose command is low never turns on.
- R2: With `dual_mode`=1 and both commands high, an off switch stays off. An on switch turns off once its minimum width has run.
- R3: With `dual_mode`=0, `ctl_hi` is ignored. `ctl_lo`=1 selects `hi_on`=1 and `lo_on`=0, and `ctl_lo`=0 selects the reverse.
- R4: `hi_on` and `lo_on` are never 1 in the same cycle. In two-input mode a handover leaves exactly one cycle with both off, whatever `dead_cycles` is set to.
- R5: In one-input mode, a switch turns on exactly `dead_cycles`+1 cycles after the opposite switch turned off.
- R6: Once a switch turns on, it stays on for at least MIN_PW_CYC = ceil(MIN_PW_NS/CLK_PERIOD_NS) cycles, even if its command was high for only one cycle.
- R7: When `enable`=0 or `por_ok`=0 is sampled at a clock edge, both outputs are 0 after that edge and stay 0 while the condition holds. Reset clears both outputs.
- R8: Take the first edge at which `enable` and `por_ok` are both sampled high as edge 1. A switch can turn on no earlier than edge EN_DELAY_CYC+1 = ceil(EN_DELAY_NS/CLK_PERIOD_NS)+1. In one-input mode the start is delayed by a further `dead_cycles` edges.
- R9: `kill_hi` or `kill_lo` sampled high turns its own switch off at that edge, even during the minimum width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dual_mode | input | 1 | 1 = two-input control, 0 = one-input complementary control |
| ctl_hi | input | 1 | High-side command (two-input mode only) |
| ctl_lo | input | 1 | Low-side command; the single command in one-input mode |
| enable | input | 1 | Run enable |
| por_ok | input | 1 | Supply has passed the power-on threshold |
| dead_cycles | input | DB_W | Break-before-make time in cycles (one-input mode) |
| kill_hi | input | 1 | Fault kill for the high side |
| kill_lo | input | 1 | Fault kill for the low side |
| hi_on | output | 1 | High-side switch on |
| lo_on | output | 1 | Low-side switch on |

## Verification
The bench measures several gaps to the exact cycle: the handover gaps in both modes with the dead time at zero and nonzero, the width of a one-cycle command, and the distance from enable rising to the first switch turning on. A design that counted the dead time from the wrong edge, or that applied it in two-input mode, would give a gap that is off by one or more. The bench also drives both commands high and changes `ctl_hi` in one-input mode. A broken interlock would then turn a switch on, and a design that decoded the wrong input would change its outputs. Kill pulses arrive while the minimum width is still running, so a design that let the width counter override a kill would keep the switch on.

// File: rtl/pp_gate_pkg.sv
package pp_gate_pkg;
   typedef enum int unsigned {
      SIDE_HI = 0,
      SIDE_LO = 1
   } side_e;

   localparam int unsigned NUM_SIDES = 2;

   // round a time up to whole clock cycles
   function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                             input int unsigned period_ns);
      return (t_ns + period_ns - 1) / period_ns;
   endfunction
endpackage

// File: rtl/pp_en_timer.sv
module pp_en_timer #(
   parameter int unsigned DELAY_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic por_ok,
   output logic gate
);
   localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1);

   logic             en_ok;
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   assign en_ok = enable & por_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (!en_ok) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (cnt_q == CNT_W'(DELAY_CYC - 1)) begin
         run_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // the off path does not wait for the register
   assign gate = run_q & en_ok;
endmodule

// File: rtl/pp_req_decode.sv
module pp_req_decode (
   input  logic       dual_mode,
   input  logic       ctl_hi,
   input  logic       ctl_lo,
   output logic [1:0] req
);
   import pp_gate_pkg::*;

   always_comb begin
      if (dual_mode) begin
         req[SIDE_HI] = ctl_hi & ~ctl_lo;
         req[SIDE_LO] = ctl_lo & ~ctl_hi;
      end else begin
         req[SIDE_HI] = ctl_lo;
         req[SIDE_LO] = ~ctl_lo;
      end
   end
endmodule

// File: rtl/pp_side.sv
module pp_side #(
   parameter int unsigned MIN_PW_CYC = 15,
   parameter int unsigned DB_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gate,
   input  logic            kill,
   input  logic            req,
   input  logic            dual_mode,
   input  logic            other_on,
   input  logic [DB_W-1:0] other_idle,
   input  logic [DB_W-1:0] dead_cycles,
   output logic            on,
   output logic [DB_W-1:0] idle
);
   localparam int unsigned PW_W = $clog2(MIN_PW_CYC + 1);

   logic [PW_W-1:0] pw_q;
   logic            may_start;

   assign may_start = req & ~other_on & (dual_mode | (other_idle >= dead_cycles));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on   <= 1'b0;
         pw_q <= '0;
      end else if (!gate || kill) begin
         on   <= 1'b0;
         pw_q <= '0;
      end else if (on) begin
         if (pw_q < PW_W'(MIN_PW_CYC)) begin
            pw_q <= pw_q + 1'b1;
         end else if (!req) begin
            on   <= 1'b0;
            pw_q <= '0;
         end
      end else if (may_start) begin
         on   <= 1'b1;
         pw_q <= PW_W'(1);
      end
   end

   // cycles since this side went off, cleared while gated
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle <= '0;
      end else if (!gate || on) begin
         idle <= '0;
      end else if (idle != {DB_W{1'b1}}) begin
         idle <= idle + 1'b1;
      end
   end
endmodule

// File: rtl/pp_gate_ctrl.sv
module pp_gate_ctrl #(
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned MIN_PW_NS     = 150,
   parameter int unsigned EN_DELAY_NS   = 100000,
   parameter int unsigned DB_W          = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dual_mode,
   input  logic            ctl_hi,
   input  logic            ctl_lo,
   input  logic            enable,
   input  logic            por_ok,
   input  logic [DB_W-1:0] dead_cycles,
   input  logic            kill_hi,
   input  logic            kill_lo,
   output logic            hi_on,
   output logic            lo_on
);
   import pp_gate_pkg::*;

   localparam int unsigned MIN_PW_CYC   = ns_to_cyc(MIN_PW_NS, CLK_PERIOD_NS);
   localparam int unsigned EN_DELAY_CYC = ns_to_cyc(EN_DELAY_NS, CLK_PERIOD_NS);

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be nonzero");
   end
   if (MIN_PW_CYC < 1) begin : g_bad_pw
      $error("MIN_PW_NS must give at least one cycle");
   end
   if (EN_DELAY_CYC < 1) begin : g_bad_en
      $error("EN_DELAY_NS must give at least one cycle");
   end
   if (DB_W < 1 || DB_W > 16) begin : g_bad_db
      $error("DB_W out of range");
   end

   logic                    gate;
   logic [NUM_SIDES-1:0]    req;
   logic [NUM_SIDES-1:0]    kill;
   logic [NUM_SIDES-1:0]    on_vec;
   logic [DB_W-1:0]         idle_arr [NUM_SIDES];

   assign kill[SIDE_HI] = kill_hi;
   assign kill[SIDE_LO] = kill_lo;

   pp_en_timer #(.DELAY_CYC(EN_DELAY_CYC)) u_en_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .por_ok (por_ok),
      .gate   (gate)
   );

   pp_req_decode u_req_decode (
      .dual_mode (dual_mode),
      .ctl_hi    (ctl_hi),
      .ctl_lo    (ctl_lo),
      .req       (req)
   );

   for (genvar gi = 0; gi < NUM_SIDES; gi++) begin : g_side
      localparam int OTHER = NUM_SIDES - 1 - gi;
      pp_side #(.MIN_PW_CYC(MIN_PW_CYC), .DB_W(DB_W)) u_side (
         .clk         (clk),
         .rst_n       (rst_n),
         .gate        (gate),
         .kill        (kill[gi]),
         .req         (req[gi]),
         .dual_mode   (dual_mode),
         .other_on    (on_vec[OTHER]),
         .other_idle  (idle_arr[OTHER]),
         .dead_cycles (dead_cycles),
         .on          (on_vec[gi]),
         .idle        (idle_arr[gi])
      );
   end

   assign hi_on = on_vec[SIDE_HI];
   assign lo_on = on_vec[SIDE_LO];
endmodule

// File: rtl/pp_gate_ctrl_chk.sv
module pp_gate_ctrl_chk #(
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned MIN_PW_NS     = 150,
   parameter int unsigned EN_DELAY_NS   = 100000,
   parameter int unsigned DB_W          = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dual_mode,
   input logic            ctl_hi,
   input logic            ctl_lo,
   input logic            enable,
   input logic            por_ok,
   input logic [DB_W-1:0] dead_cycles,
   input logic            kill_hi,
   input logic            kill_lo,
   input logic            hi_on,
   input logic            lo_on
);
   import pp_gate_pkg::*;

   localparam int unsigned MIN_PW_CYC   = ns_to_cyc(MIN_PW_NS, CLK_PERIOD_NS);
   localparam int unsigned EN_DELAY_CYC = ns_to_cyc(EN_DELAY_NS, CLK_PERIOD_NS);
   localparam int unsigned RUN_W        = $clog2(MIN_PW_CYC + 1);
   localparam int unsigned IDL_W        = DB_W + 1;
   localparam int unsigned ENC_W        = $clog2(EN_DELAY_CYC + 2) + 1;

   logic             en_ok;
   logic [RUN_W-1:0] hi_run, lo_run;
   logic [IDL_W-1:0] hi_idle, lo_idle;
   logic [ENC_W-1:0] en_cnt;

   assign en_ok = enable & por_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run  <= '0;
         lo_run  <= '0;
         hi_idle <= '0;
         lo_idle <= '0;
         en_cnt  <= '0;
      end else begin
         hi_run  <= !hi_on ? '0 : (hi_run == RUN_W'(MIN_PW_CYC) ? hi_run : hi_run + 1'b1);
         lo_run  <= !lo_on ? '0 : (lo_run == RUN_W'(MIN_PW_CYC) ? lo_run : lo_run + 1'b1);
         hi_idle <= hi_on ? '0 : (hi_idle == {IDL_W{1'b1}} ? hi_idle : hi_idle + 1'b1);
         lo_idle <= lo_on ? '0 : (lo_idle == {IDL_W{1'b1}} ? lo_idle : lo_idle + 1'b1);
         en_cnt  <= !en_ok ? '0 : (en_cnt == {ENC_W{1'b1}} ? en_cnt : en_cnt + 1'b1);
      end
   end

   AST_DUAL_HI_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      dual_mode && !ctl_hi && !hi_on |=> !hi_on); // R1
   AST_DUAL_LO_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      dual_mode && !ctl_lo && !lo_on |=> !lo_on); // R1
   AST_DUAL_BOTH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      dual_mode && ctl_hi && ctl_lo && !hi_on && !lo_on |=> !hi_on && !lo_on); // R2
   AST_SINGLE_LO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_mode && ctl_lo && !lo_on |=> !lo_on); // R3
   AST_SINGLE_HI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_mode && !ctl_lo && !hi_on |=> !hi_on); // R3
   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_on && lo_on)); // R4
   AST_DEAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_on) && !$past(dual_mode) |-> lo_idle > IDL_W'($past(dead_cycles))); // R5
   AST_DEAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_on) && !$past(dual_mode) |-> hi_idle > IDL_W'($past(dead_cycles))); // R5
   AST_MIN_PW_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hi_on) && $past(en_ok && !kill_hi) |-> hi_run >= RUN_W'(MIN_PW_CYC)); // R6
   AST_MIN_PW_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lo_on) && $past(en_ok && !kill_lo) |-> lo_run >= RUN_W'(MIN_PW_CYC)); // R6
   AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_ok |=> !hi_on && !lo_on); // R7
   AST_EN_DELAY_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_on) |-> en_cnt > ENC_W'(EN_DELAY_CYC)); // R8
   AST_EN_DELAY_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_on) |-> en_cnt > ENC_W'(EN_DELAY_CYC)); // R8
   AST_KILL_HI: assert property (@(posedge clk) disable iff (!rst_n)
      kill_hi |=> !hi_on); // R9
   AST_KILL_LO: assert property (@(posedge clk) disable iff (!rst_n)
      kill_lo |=> !lo_on); // R9
endmodule

bind pp_gate_ctrl pp_gate_ctrl_chk #(
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .MIN_PW_NS     (MIN_PW_NS),
   .EN_DELAY_NS   (EN_DELAY_NS),
   .DB_W          (DB_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dual_mode   (dual_mode),
   .ctl_hi      (ctl_hi),
   .ctl_lo      (ctl_lo),
   .enable      (enable),
   .por_ok      (por_ok),
   .dead_cycles (dead_cycles),
   .kill_hi     (kill_hi),
   .kill_lo     (kill_lo),
   .hi_on       (hi_on),
   .lo_on       (lo_on)
);

// File: tb/pp_gate_ctrl_bench.sv
module pp_gate_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DB_W       = 8;
   localparam int MIN_PW     = 15;   // 150 ns at 10 ns
   localparam int EN_DLY     = 40;   // 400 ns at 10 ns

   // {dual, ctl_hi, ctl_lo, exp_hi, exp_lo}
   localparam logic [4:0] VEC [9] = '{
      5'b11010, 5'b10101, 5'b11100, 5'b10000, 5'b11010,
      5'b00110, 5'b00001, 5'b01110, 5'b01001
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            dual_mode = 1'b1;
   logic            ctl_hi = 1'b0;
   logic            ctl_lo = 1'b0;
   logic            enable = 1'b0;
   logic            por_ok = 1'b1;
   logic [DB_W-1:0] dead_cycles = 8'd3;
   logic            kill_hi = 1'b0;
   logic            kill_lo = 1'b0;
   logic            hi_on, lo_on;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pp_gate_ctrl #(
      .CLK_PERIOD_NS (CLK_PERIOD),
      .MIN_PW_NS     (MIN_PW * CLK_PERIOD),
      .EN_DELAY_NS   (EN_DLY * CLK_PERIOD),
      .DB_W          (DB_W)
   ) u_pp_gate_ctrl (
      .clk (clk), .rst_n (rst_n), .dual_mode (dual_mode),
      .ctl_hi (ctl_hi), .ctl_lo (ctl_lo), .enable (enable), .por_ok (por_ok),
      .dead_cycles (dead_cycles), .kill_hi (kill_hi), .kill_lo (kill_lo),
      .hi_on (hi_on), .lo_on (lo_on)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycles from enable sampled high until hi_on is seen
   task automatic time_to_hi(output int k);
      k = 0;
      for (int i = 1; i <= 400; i++) begin
         step();
         if (hi_on) begin
            k = i;
            break;
         end
      end
   endtask

   // after a command change: wait for the old side to drop, count both-off samples
   task automatic handover_gap(input bit from_hi, output int g);
      g = 0;
      for (int i = 0; i < 100; i++) begin
         step();
         if (!(from_hi ? hi_on : lo_on)) break;
      end
      g = 1;
      for (int i = 0; i < 300; i++) begin
         step();
         if (hi_on || lo_on) break;
         g++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R7", "reset hi_on", hi_on, 0);
      chk("R7", "reset lo_on", lo_on, 0);

      // R8: enable delay in dual mode
      ctl_hi = 1'b1;
      enable = 1'b1;
      time_to_hi(k);
      chk("R8", "dual start cycles", k, EN_DLY + 1);

      // table walk: R1, R2, R3
      for (int v = 0; v < 9; v++) begin
         dual_mode = VEC[v][4];
         ctl_hi    = VEC[v][3];
         ctl_lo    = VEC[v][2];
         repeat (40) step();
         chk(VEC[v][4] ? ((VEC[v][3] && VEC[v][2]) ? "R2" : "R1") : "R3",
             $sformatf("vec %0d hi_on", v), hi_on, VEC[v][1]);
         chk(VEC[v][4] ? ((VEC[v][3] && VEC[v][2]) ? "R2" : "R1") : "R3",
             $sformatf("vec %0d lo_on", v), lo_on, VEC[v][0]);
      end

      // R5: single-mode dead time, hi -> lo with 5, lo -> hi with 0
      dual_mode = 1'b0; ctl_hi = 1'b0; ctl_lo = 1'b1; dead_cycles = 8'd5;
      repeat (40) step();
      ctl_lo = 1'b0;
      handover_gap(1'b1, k);
      chk("R5", "gap hi->lo dead 5", k, 6);
      chk("R5", "lo on after gap", lo_on, 1);
      repeat (30) step();
      dead_cycles = 8'd0;
      ctl_lo = 1'b1;
      handover_gap(1'b0, k);
      chk("R5", "gap lo->hi dead 0", k, 1);

      // R4: dual handover ignores dead time
      dead_cycles = 8'd5;
      dual_mode = 1'b1; ctl_hi = 1'b1; ctl_lo = 1'b0;
      repeat (40) step();
      ctl_hi = 1'b0; ctl_lo = 1'b1;
      handover_gap(1'b1, k);
      chk("R4", "dual handover gap", k, 1);
      chk("R4", "lo on after handover", lo_on, 1);

      // R6: one-cycle command stretched
      ctl_lo = 1'b0;
      repeat (40) step();
      ctl_hi = 1'b1;
      step();
      ctl_hi = 1'b0;
      k = 0;
      for (int i = 0; i < 40; i++) begin
         if (hi_on) k++;
         step();
      end
      chk("R6", "stretched width", k, MIN_PW);

      // R9: kill during minimum width
      ctl_hi = 1'b1;
      step();
      ctl_hi = 1'b0;
      step();
      chk("R9", "hi on before kill", hi_on, 1);
      kill_hi = 1'b1;
      step();
      chk("R9", "hi off after kill", hi_on, 0);
      kill_hi = 1'b0;
      step();
      chk("R9", "hi stays off", hi_on, 0);
      ctl_lo = 1'b1;
      repeat (5) step();
      kill_lo = 1'b1;
      step();
      chk("R9", "lo off after kill", lo_on, 0);
      kill_lo = 1'b0;
      ctl_lo = 1'b0;
      repeat (30) step();

      // R7: enable and por_ok drop
      ctl_hi = 1'b1;
      repeat (30) step();
      enable = 1'b0;
      step();
      chk("R7", "enable low hi_on", hi_on, 0);
      enable = 1'b1;
      por_ok = 1'b0;
      repeat (60) step();
      chk("R7", "por low hi_on", hi_on, 0);
      chk("R7", "por low lo_on", lo_on, 0);
      por_ok = 1'b1;
      time_to_hi(k);
      chk("R8", "restart after por", k, EN_DLY + 1);

      // R8: single-mode start passes through dead time
      dual_mode = 1'b0; ctl_lo = 1'b1; ctl_hi = 1'b0; dead_cycles = 8'd5;
      enable = 1'b0;
      step();
      enable = 1'b1;
      time_to_hi(k);
      chk("R8", "single start cycles", k, EN_DLY + 1 + 5);
      chk("R8", "single start lo_on", lo_on, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule